// File: doc/BRIEF.md
# Descriptor-Ring Channel Enable and Abort Controller

This block is the control and status slice of one channel of a descriptor-ring DMA engine. Software writes a control word with three bits: run, rewind and kill. Software also reads a status word. The status word shows the current descriptor pointer, the run and active bits, and two sticky flags, one for a completion interrupt and one for a read error. The block keeps the ring pointer and decides when the next descriptor starts. It lets software stop the channel in two ways. A soft stop lets the transfer in flight finish. A kill abandons the transfer at once and skips to the following descriptor.

A separate transfer engine does the data movement. The block tells it to begin with a one-cycle `xfer_start` carrying the descriptor address, and tells it to drop an abandoned transfer with `xfer_cancel`. The engine reports back with `xfer_done`, which carries the descriptor's interrupt-request bit on `xfer_irq_req`, and with `xfer_rd_err`. Reading the status word clears both sticky flags. The single `irq` line is high while either flag is set.

Top module: `dma_chan_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the channel has run and active low, both flags low, `irq` low, `xfer_start` and `xfer_cancel` low, and a pointer of zero.
- R2: A control write with rewind=1 and run=0 on an inactive channel loads the pointer with `cfg_ring_base` on the next cycle. A write with rewind=1 and run=1 leaves the pointer unchanged.
- R3: A rewind with run=0 during a soft stop is held pending. When the in-flight transfer finishes, the pointer is loaded with the ring base instead of advancing.
- R4: When a write leaves run set on an inactive channel, `xfer_start` is high for exactly one cycle on the next cycle, with `xfer_addr` equal to the pointer. While run stays set, each `xfer_done` is followed on the next cycle by another start.
- R5: Each finished or abandoned descriptor advances the pointer by DSCR_BYTES. After `cfg_ring_len` descriptors the pointer wraps back to `cfg_ring_base`.
- R6: A write with run=0 and kill=0 keeps active high and issues no cancel until `xfer_done`. After that, active is low and no new start is issued. A later run write resumes at the following descriptor.
- R7: A write with run=0 and kill=1 on an active channel has four effects on the next cycle. Active goes low, `xfer_cancel` is high for one cycle, and the pointer moves to the next descriptor. The rest of that transfer is never started again.
- R8: A `xfer_done` with `xfer_irq_req`=1 sets the interrupt flag and `irq` on the next cycle. A `xfer_done` with `xfer_irq_req`=0 sets neither.
- R9: `xfer_rd_err` on an active channel has three effects on the next cycle. The error flag and `irq` are set, run and active are cleared, and the pointer advances.
- R10: A pulse on `rd_status` clears both flags and `irq` on the next cycle. If a set event for a flag arrives in the same cycle as the read, that flag stays set.
- R11: `xfer_done` and `xfer_rd_err` have no effect on an inactive channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Address of the first descriptor in the ring |
| cfg_ring_len | input | RING_W | Number of descriptors in the ring (1 or more) |
| wr_valid | input | 1 | Control write strobe |
| wr_enable | input | 1 | Run bit of the control write |
| wr_reset | input | 1 | Rewind bit of the control write |
| wr_abort | input | 1 | Kill bit of the control write |
| rd_status | input | 1 | Status read strobe; clears the flags |
| xfer_start | output | 1 | One-cycle launch of the descriptor at `xfer_addr` |
| xfer_addr | output | ADDR_W | Address of the descriptor being launched or run |
| xfer_cancel | output | 1 | One-cycle order to drop the transfer in flight |
| xfer_done | input | 1 | Engine finished the current descriptor |
| xfer_irq_req | input | 1 | Interrupt bit of the finished descriptor |
| xfer_rd_err | input | 1 | Engine saw a read error |
| status_ptr | output | ADDR_W | Current descriptor pointer |
| status_enabled | output | 1 | Run bit as held by the channel |
| status_active | output | 1 | Channel has a transfer launched or in flight |
| status_intr_flag | output | 1 | Sticky completion-interrupt flag |
| status_err_flag | output | 1 | Sticky read-error flag |
| irq | output | 1 | Channel interrupt line |

## Verification
The assertions check the following on every cycle:
- every start lasts exactly one cycle and only occurs while active;
- a kill always brings a cancel and inactivity;
- a read error always leaves the channel stopped with the error flag set;
- a soft stop never drops active before completion;
- the pointer never moves while the channel is idle and unwritten;
- a plain status read clears the flags;
- a flagged completion always sets the interrupt flag.

Only the directed scenarios can show the following:
- the exact pointer values across the ring wrap;
- the deferred rewind during a soft stop;
- resumption at the correct descriptor after a soft stop, a kill or an error;
- a set event winning over a read that arrives in the same cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_LAUNCH = 2'd1,
    CH_BUSY   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_enable,
  input  logic wr_reset,
  input  logic wr_abort,
  input  logic xfer_done,
  input  logic xfer_rd_err,
  output logic enabled,
  output logic active,
  output logic start,
  output logic cancel,
  output logic ptr_load,
  output logic ptr_adv,
  output logic done_evt,
  output logic err_evt
);
  ch_state_e state_q, state_d;
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic cancel_q, cancel_d;
  logic in_flight, abort_evt, rst_req, finish;

  // Event decode
  always_comb begin
    in_flight = (state_q != CH_IDLE);
    done_evt  = (state_q == CH_BUSY) && xfer_done;
    err_evt   = in_flight && xfer_rd_err;
    abort_evt = in_flight && wr_valid && !wr_enable && wr_abort;
    rst_req   = wr_valid && wr_reset && !wr_enable;
    finish    = done_evt || err_evt || abort_evt;
  end

  // Next-state logic
  always_comb begin
    en_d = en_q;
    if (err_evt)       en_d = 1'b0;
    else if (wr_valid) en_d = wr_enable;

    state_d = state_q;
    unique case (state_q)
      CH_IDLE:   if (en_d) state_d = CH_LAUNCH;
      CH_LAUNCH: state_d = (err_evt || abort_evt) ? CH_IDLE : CH_BUSY;
      CH_BUSY: begin
        if (err_evt || abort_evt) state_d = CH_IDLE;
        else if (done_evt)        state_d = en_d ? CH_LAUNCH : CH_IDLE;
      end
      default:   state_d = CH_IDLE;
    endcase

    ptr_load = (rst_req && !in_flight) || ((rst_req || pend_q) && finish);
    ptr_adv  = finish && !ptr_load;

    pend_d = pend_q;
    if (finish)                     pend_d = 1'b0;
    else if (rst_req && in_flight)  pend_d = 1'b1;

    cancel_d = abort_evt;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      en_q     <= en_d;
      pend_q   <= pend_d;
      cancel_q <= cancel_d;
    end
  end

  assign enabled = en_q;
  assign active  = in_flight;
  assign start   = (state_q == CH_LAUNCH);
  assign cancel  = cancel_q;
endmodule

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr #(
  parameter int ADDR_W     = 32,
  parameter int RING_W     = 8,
  parameter int DSCR_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [RING_W-1:0] ring_len,
  input  logic              load,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(DSCR_BYTES);
  localparam logic [RING_W-1:0] IDX_ONE = RING_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [RING_W-1:0] idx_q, idx_d;
  logic              at_last;

  always_comb begin
    at_last = (idx_q == (ring_len - IDX_ONE));
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    if (load) begin
      ptr_d = base;
      idx_d = '0;
    end else if (adv) begin
      if (at_last) begin
        ptr_d = base;
        idx_d = '0;
      end else begin
        ptr_d = ptr_q + STEP;
        idx_d = idx_q + IDX_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else if (load || adv) begin
      ptr_q <= ptr_d;
      idx_q <= idx_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dma_status_flags.sv
module dma_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic irq_req,
  input  logic err_evt,
  input  logic rd_clr,
  output logic intr_flag,
  output logic err_flag,
  output logic irq
);
  logic intr_q, intr_d, err_q, err_d;
  logic set_intr;

  always_comb begin
    set_intr = done_evt && irq_req && !err_evt;
    intr_d   = set_intr || (intr_q && !rd_clr);
    err_d    = err_evt  || (err_q  && !rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      intr_q <= intr_d;
      err_q  <= err_d;
    end
  end

  assign intr_flag = intr_q;
  assign err_flag  = err_q;
  assign irq       = intr_q || err_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int RING_W     = 8,
  parameter int DSCR_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [RING_W-1:0] cfg_ring_len,
  input  logic              wr_valid,
  input  logic              wr_enable,
  input  logic              wr_reset,
  input  logic              wr_abort,
  input  logic              rd_status,
  output logic              xfer_start,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_cancel,
  input  logic              xfer_done,
  input  logic              xfer_irq_req,
  input  logic              xfer_rd_err,
  output logic [ADDR_W-1:0] status_ptr,
  output logic              status_enabled,
  output logic              status_active,
  output logic              status_intr_flag,
  output logic              status_err_flag,
  output logic              irq
);
  logic ptr_load, ptr_adv, done_evt, err_evt;
  logic [ADDR_W-1:0] ptr;

  dma_chan_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_enable   (wr_enable),
    .wr_reset    (wr_reset),
    .wr_abort    (wr_abort),
    .xfer_done   (xfer_done),
    .xfer_rd_err (xfer_rd_err),
    .enabled     (status_enabled),
    .active      (status_active),
    .start       (xfer_start),
    .cancel      (xfer_cancel),
    .ptr_load    (ptr_load),
    .ptr_adv     (ptr_adv),
    .done_evt    (done_evt),
    .err_evt     (err_evt)
  );

  dma_ring_ptr #(
    .ADDR_W     (ADDR_W),
    .RING_W     (RING_W),
    .DSCR_BYTES (DSCR_BYTES)
  ) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (cfg_ring_base),
    .ring_len (cfg_ring_len),
    .load     (ptr_load),
    .adv      (ptr_adv),
    .ptr      (ptr)
  );

  dma_status_flags flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (done_evt),
    .irq_req   (xfer_irq_req),
    .err_evt   (err_evt),
    .rd_clr    (rd_status),
    .intr_flag (status_intr_flag),
    .err_flag  (status_err_flag),
    .irq       (irq)
  );

  assign status_ptr = ptr;
  assign xfer_addr  = ptr;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_enable,
  input logic              wr_abort,
  input logic              rd_status,
  input logic              xfer_start,
  input logic              xfer_cancel,
  input logic              xfer_done,
  input logic              xfer_irq_req,
  input logic              xfer_rd_err,
  input logic [ADDR_W-1:0] status_ptr,
  input logic              status_enabled,
  input logic              status_active,
  input logic              status_intr_flag,
  input logic              status_err_flag,
  input logic              irq
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R4
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> status_active); // R4
  AST_KILL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_active && wr_valid && !wr_enable && wr_abort) |=> (xfer_cancel && !status_active)); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_active && xfer_rd_err) |=> (!status_active && !status_enabled && status_err_flag && irq)); // R9
  AST_SOFT_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_active && wr_valid && !wr_enable && !wr_abort && !xfer_done && !xfer_rd_err)
      |=> (status_active && !xfer_cancel)); // R6
  AST_IDLE_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_active && !wr_valid) |=> $stable(status_ptr)); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !(status_active && (xfer_done || xfer_rd_err)))
      |=> (!status_intr_flag && !status_err_flag && !irq)); // R10
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_active && !xfer_start && xfer_done && xfer_irq_req && !xfer_rd_err)
      |=> (status_intr_flag && irq)); // R8
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_valid         (wr_valid),
  .wr_enable        (wr_enable),
  .wr_abort         (wr_abort),
  .rd_status        (rd_status),
  .xfer_start       (xfer_start),
  .xfer_cancel      (xfer_cancel),
  .xfer_done        (xfer_done),
  .xfer_irq_req     (xfer_irq_req),
  .xfer_rd_err      (xfer_rd_err),
  .status_ptr       (status_ptr),
  .status_enabled   (status_enabled),
  .status_active    (status_active),
  .status_intr_flag (status_intr_flag),
  .status_err_flag  (status_err_flag),
  .irq              (irq)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;
  localparam int ADDR_W = 32;
  localparam int RING_W = 8;
  localparam int STEP   = 16;
  localparam int RLEN   = 3;
  localparam logic [ADDR_W-1:0] BASE = 32'h0000_1000;

  logic clk, rst_n;
  logic [ADDR_W-1:0] cfg_ring_base;
  logic [RING_W-1:0] cfg_ring_len;
  logic wr_valid, wr_enable, wr_reset, wr_abort, rd_status;
  logic xfer_start, xfer_cancel, xfer_done, xfer_irq_req, xfer_rd_err;
  logic [ADDR_W-1:0] xfer_addr, status_ptr;
  logic status_enabled, status_active, status_intr_flag, status_err_flag, irq;

  int n_run, n_fail, exp_idx;
  bit finished;

  dma_chan_ctrl #(.ADDR_W(ADDR_W), .RING_W(RING_W), .DSCR_BYTES(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
    .wr_valid(wr_valid), .wr_enable(wr_enable), .wr_reset(wr_reset), .wr_abort(wr_abort),
    .rd_status(rd_status), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .xfer_cancel(xfer_cancel), .xfer_done(xfer_done), .xfer_irq_req(xfer_irq_req),
    .xfer_rd_err(xfer_rd_err), .status_ptr(status_ptr), .status_enabled(status_enabled),
    .status_active(status_active), .status_intr_flag(status_intr_flag),
    .status_err_flag(status_err_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [ADDR_W-1:0] addr_of(int idx);
    return BASE + ADDR_W'(idx * STEP);
  endfunction

  task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ctl_write(logic en, logic rw, logic kill);
    wr_valid = 1'b1; wr_enable = en; wr_reset = rw; wr_abort = kill;
    tick();
    wr_valid = 1'b0; wr_enable = 1'b0; wr_reset = 1'b0; wr_abort = 1'b0;
  endtask

  task automatic eng_done(logic irqb, logic rd);
    xfer_done = 1'b1; xfer_irq_req = irqb; rd_status = rd;
    tick();
    xfer_done = 1'b0; xfer_irq_req = 1'b0; rd_status = 1'b0;
  endtask

  task automatic eng_err(logic rd);
    xfer_rd_err = 1'b1; rd_status = rd;
    tick();
    xfer_rd_err = 1'b0; rd_status = 1'b0;
  endtask

  task automatic st_read();
    rd_status = 1'b1;
    tick();
    rd_status = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 active", 32'(status_active), 0);
    chk("R1 enabled", 32'(status_enabled), 0);
    chk("R1 flags/irq", {29'd0, status_intr_flag, status_err_flag, irq}, 0);
    chk("R1 start/cancel", {30'd0, xfer_start, xfer_cancel}, 0);
    chk("R1 ptr", status_ptr, 0);
  endtask

  task automatic t_rewind_idle();
    ctl_write(1'b0, 1'b1, 1'b0);
    exp_idx = 0;
    chk("R2 rewind loads base", status_ptr, BASE);
    chk("R2 stays idle", 32'(status_active), 0);
  endtask

  task automatic t_run_wrap();
    ctl_write(1'b1, 1'b0, 1'b0);
    chk("R4 start after run", 32'(xfer_start), 1);
    chk("R4 addr", xfer_addr, addr_of(exp_idx));
    tick();
    chk("R4 start one cycle", 32'(xfer_start), 0);
    for (int k = 0; k < RLEN; k++) begin
      eng_done(1'b0, 1'b0);
      exp_idx = (exp_idx + 1) % RLEN;
      chk("R5 advance/wrap", status_ptr, addr_of(exp_idx));
      chk("R4 relaunch", 32'(xfer_start), 1);
      tick();
    end
    chk("R5 wrapped to base", status_ptr, BASE);
  endtask

  task automatic t_soft_stop();
    eng_done(1'b0, 1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    tick();
    ctl_write(1'b1, 1'b1, 1'b0);
    chk("R2 rewind ignored with run", status_ptr, addr_of(exp_idx));
    ctl_write(1'b0, 1'b0, 1'b0);
    chk("R6 still active", 32'(status_active), 1);
    chk("R6 run cleared", 32'(status_enabled), 0);
    chk("R6 no cancel", 32'(xfer_cancel), 0);
    tick();
    chk("R6 still active later", 32'(status_active), 1);
    eng_done(1'b0, 1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R6 inactive after done", 32'(status_active), 0);
    chk("R6 no new start", 32'(xfer_start), 0);
    tick();
    chk("R6 stays stopped", 32'(xfer_start), 0);
    ctl_write(1'b1, 1'b0, 1'b0);
    chk("R6 resume start", 32'(xfer_start), 1);
    chk("R6 resume addr", xfer_addr, addr_of(exp_idx));
    tick();
  endtask

  task automatic t_kill();
    ctl_write(1'b0, 1'b0, 1'b1);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R7 inactive", 32'(status_active), 0);
    chk("R7 cancel", 32'(xfer_cancel), 1);
    chk("R7 skip ptr", status_ptr, addr_of(exp_idx));
    tick();
    chk("R7 cancel one cycle", 32'(xfer_cancel), 0);
    eng_done(1'b1, 1'b0);
    chk("R11 done idle ptr", status_ptr, addr_of(exp_idx));
    chk("R11 done idle flag", 32'(status_intr_flag), 0);
    eng_err(1'b0);
    chk("R11 err idle flag", 32'(status_err_flag), 0);
    chk("R11 err idle irq", 32'(irq), 0);
    ctl_write(1'b1, 1'b0, 1'b0);
    chk("R7 resume next", xfer_addr, addr_of(exp_idx));
    tick();
  endtask

  task automatic t_deferred_rewind();
    eng_done(1'b0, 1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    tick();
    ctl_write(1'b0, 1'b1, 1'b0);
    chk("R3 not yet loaded", status_ptr, addr_of(exp_idx));
    eng_done(1'b0, 1'b0);
    exp_idx = 0;
    chk("R3 loaded at finish", status_ptr, BASE);
    chk("R3 inactive", 32'(status_active), 0);
  endtask

  task automatic t_intr();
    ctl_write(1'b1, 1'b0, 1'b0);
    tick();
    eng_done(1'b1, 1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R8 intr flag", 32'(status_intr_flag), 1);
    chk("R8 irq", 32'(irq), 1);
    st_read();
    chk("R10 read clears", {30'd0, status_intr_flag, irq}, 0);
    eng_done(1'b0, 1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R8 no flag without request", 32'(status_intr_flag), 0);
    tick();
    eng_done(1'b1, 1'b1);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R10 set beats read", 32'(status_intr_flag), 1);
    st_read();
    chk("R10 later read clears", 32'(status_intr_flag), 0);
  endtask

  task automatic t_err();
    eng_err(1'b0);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R9 err flag", 32'(status_err_flag), 1);
    chk("R9 irq", 32'(irq), 1);
    chk("R9 stopped", {30'd0, status_active, status_enabled}, 0);
    chk("R9 ptr advanced", status_ptr, addr_of(exp_idx));
    tick();
    chk("R9 no start", 32'(xfer_start), 0);
    st_read();
    ctl_write(1'b1, 1'b0, 1'b0);
    eng_err(1'b1);
    exp_idx = (exp_idx + 1) % RLEN;
    chk("R10 err beats read", 32'(status_err_flag), 1);
    st_read();
    chk("R10 err cleared", {30'd0, status_err_flag, irq}, 0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; exp_idx = 0; finished = 0;
    rst_n = 1'b0;
    cfg_ring_base = BASE; cfg_ring_len = RING_W'(RLEN);
    wr_valid = 0; wr_enable = 0; wr_reset = 0; wr_abort = 0; rd_status = 0;
    xfer_done = 0; xfer_irq_req = 0; xfer_rd_err = 0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rewind_idle();
    t_run_wrap();
    t_soft_stop();
    t_kill();
    t_deferred_rewind();
    t_intr();
    t_err();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule